// File: doc/BRIEF.md
# Inter-core mailbox doorbell unit

This unit gives each of four cores four 32-bit doorbell mailboxes (sixteen in all) for signalling between processors. Any core may raise bits in any mailbox through a write-set address. The owning core reads its mailbox and acknowledges single bits through a separate write-one-to-clear alias of the same word. Because of this, acknowledging one bit never needs a read-modify-write and never loses a bit that another core raised in the meantime.

Each core has a small configuration register. For every mailbox, this register holds one enable bit that turns the nonzero mailbox into a normal interrupt request and another that turns it into a fast interrupt request. The unit drives one registered pending flag per mailbox and one normal and one fast interrupt line per core.

The register port has two independent write channels and one read channel. This lets two masters reach the unit in the same cycle. How those masters are arbitrated and how the interrupt lines are routed onward are left to the surrounding logic.

Top module: `mbx_doorbell`

## Requirements
- R1: A write to the set address 0x80 + 16n + 4m ORs the write data into mailbox m of core n (n, m in 0..3), and bits already set stay set.
- R2: A write to the clear address 0xC0 + 16n + 4m clears exactly those bits of mailbox m of core n that are written as one. Bits written as zero and all other mailboxes are unchanged.
- R3: A read with rd_en high samples rd_addr on a clock edge, and rd_data holds the result from that edge on. A read of a clear address returns the mailbox contents as they stood before that edge.
- R4: A read of a set address, of a misaligned address or of any unmapped address returns zero. A write to a misaligned or unmapped address changes no mailbox and no configuration register.
- R5: After a synchronous reset, every mailbox is zero, every pending flag and interrupt line is low, rd_data is zero and each configuration register holds 0x01 (mailbox 0 enabled as a normal interrupt source).
- R6: Core n's configuration register is read and written at 0x20 + 4n. Bit m enables mailbox m as a normal interrupt source and bit m+4 enables it as a fast interrupt source. Only bits 7:0 are stored, and the upper read bits are zero.
- R7: mbox_pend bit 4n+m is high exactly when mailbox m of core n is nonzero. The flag changes on the same edge as the mailbox contents.
- R8: irq[n] is the OR over m of (mailbox m of core n nonzero AND configuration bit m), and fiq[n] uses bit m+4 in the same way. Both change on the clock edge that samples the write causing the change.
- R9: When one write channel sets and the other clears the same mailbox in the same cycle, the result is (old AND NOT clear) OR set, so a newly raised bit survives.
- R10: Two set writes to the same mailbox in one cycle OR both data words in. When both channels write the same configuration register in one cycle, channel 1's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr0_en | input | 1 | Write channel 0 strobe |
| wr0_addr | input | 8 | Write channel 0 byte address |
| wr0_data | input | 32 | Write channel 0 data |
| wr1_en | input | 1 | Write channel 1 strobe |
| wr1_addr | input | 8 | Write channel 1 byte address |
| wr1_data | input | 32 | Write channel 1 data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Registered read data |
| mbox_pend | output | 16 | Per-mailbox nonzero flags, index 4n+m |
| irq | output | 4 | Per-core normal interrupt request |
| fiq | output | 4 | Per-core fast interrupt request |

## Verification
A doorbell raise and an acknowledge can land on the same mailbox in the same cycle: one write channel hits the set alias while the other hits the clear alias. The bench drives both channels on one edge with overlapping and disjoint bit patterns, including clear masks that cover the newly set bits. The stored word is judged against (old AND NOT clear) OR set, and the pending and interrupt outputs are judged against what that word implies. Two configuration writes to one register in the same cycle are provoked in the same way, and only channel 1's value is expected to be stored.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int MBX_CORES    = 4;
  localparam int MBX_PER_CORE = 4;
  localparam int MBX_DW       = 32;
  localparam int MBX_AW       = 8;
  localparam int MBX_SET_BASE = 'h80;
  localparam int MBX_CLR_BASE = 'hC0;
  localparam int MBX_CFG_BASE = 'h20;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode #(
  parameter int N        = 4,
  parameter int M        = 4,
  parameter int AW       = 8,
  parameter int SET_BASE = 'h80,
  parameter int CLR_BASE = 'hC0,
  parameter int CFG_BASE = 'h20
) (
  input  logic            en,
  input  logic [AW-1:0]   addr,
  output logic [N*M-1:0]  set_vec,
  output logic [N*M-1:0]  clr_vec,
  output logic [N-1:0]    cfg_vec
);
  localparam int TOT   = N * M;
  localparam int SPAN  = 4 * TOT;
  localparam int CSPAN = 4 * N;

  logic [AW-1:0] set_off, clr_off, cfg_off;
  logic aligned, set_hit, clr_hit, cfg_hit;

  assign aligned = (addr[1:0] == 2'b00);
  assign set_off = addr - AW'(SET_BASE);
  assign clr_off = addr - AW'(CLR_BASE);
  assign cfg_off = addr - AW'(CFG_BASE);
  assign set_hit = en && aligned && (addr >= AW'(SET_BASE)) && (set_off < AW'(SPAN));
  assign clr_hit = en && aligned && (addr >= AW'(CLR_BASE)) && (clr_off < AW'(SPAN));
  assign cfg_hit = en && aligned && (addr >= AW'(CFG_BASE)) && (cfg_off < AW'(CSPAN));

  for (genvar i = 0; i < TOT; i++) begin : g_mbx
    assign set_vec[i] = set_hit && (set_off[AW-1:2] == (AW-2)'(i));
    assign clr_vec[i] = clr_hit && (clr_off[AW-1:2] == (AW-2)'(i));
  end
  for (genvar n = 0; n < N; n++) begin : g_cfg
    assign cfg_vec[n] = cfg_hit && (cfg_off[AW-1:2] == (AW-2)'(n));
  end
endmodule

// File: rtl/mbx_cell.sv
module mbx_cell #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] set_mask,
  input  logic [DW-1:0] clr_mask,
  output logic [DW-1:0] q_o,
  output logic          nz_next_o,
  output logic          pend_o
);
  logic [DW-1:0] q_next;

  // A set bit always wins over a clear of the same bit
  assign q_next    = (q_o & ~clr_mask) | set_mask;
  assign nz_next_o = |q_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_o    <= '0;
      pend_o <= 1'b0;
    end else begin
      q_o    <= q_next;
      pend_o <= nz_next_o;
    end
  end

  AST_MBX_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (q_o == '0)); // R5
  AST_SET_SURVIVES: assert property (@(posedge clk) disable iff (rst)
    (|set_mask) |=> ((q_o & $past(set_mask)) == $past(set_mask))); // R9
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (|(clr_mask & ~set_mask)) |=> ((q_o & $past(clr_mask & ~set_mask)) == '0)); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (set_mask == '0 && clr_mask == '0) |=> $stable(q_o)); // R1
endmodule

// File: rtl/mbx_core_irq.sv
module mbx_core_irq #(
  parameter int               M       = 4,
  parameter logic [2*M-1:0]   RST_CFG = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we0,
  input  logic [2*M-1:0] wd0,
  input  logic           we1,
  input  logic [2*M-1:0] wd1,
  input  logic [M-1:0]   nz_next,
  output logic [2*M-1:0] cfg_q,
  output logic           irq_o,
  output logic           fiq_o
);
  logic [2*M-1:0] cfg_next;

  // Channel 1 takes priority on a same-cycle collision
  always_comb begin
    cfg_next = cfg_q;
    if (we0) cfg_next = wd0;
    if (we1) cfg_next = wd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= RST_CFG;
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      cfg_q <= cfg_next;
      irq_o <= |(nz_next & cfg_next[M-1:0]);
      fiq_o <= |(nz_next & cfg_next[2*M-1:M]);
    end
  end

  AST_CFG_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_q == RST_CFG)); // R5
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (|cfg_q[M-1:0])); // R8
  AST_FIQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    fiq_o |-> (|cfg_q[2*M-1:M])); // R8
  AST_CFG_PRIO: assert property (@(posedge clk) disable iff (rst)
    (we0 && we1) |=> (cfg_q == $past(wd1))); // R10
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
  import mbx_pkg::*;
#(
  parameter int N        = MBX_CORES,
  parameter int M        = MBX_PER_CORE,
  parameter int DW       = MBX_DW,
  parameter int AW       = MBX_AW,
  parameter int SET_BASE = MBX_SET_BASE,
  parameter int CLR_BASE = MBX_CLR_BASE,
  parameter int CFG_BASE = MBX_CFG_BASE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr0_en,
  input  logic [AW-1:0]     wr0_addr,
  input  logic [DW-1:0]     wr0_data,
  input  logic              wr1_en,
  input  logic [AW-1:0]     wr1_addr,
  input  logic [DW-1:0]     wr1_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic [N*M-1:0]    mbox_pend,
  output logic [N-1:0]      irq,
  output logic [N-1:0]      fiq
);
  localparam int TOT = N * M;
  localparam int CW  = 2 * M;

  logic [TOT-1:0] w0_set, w0_clr, w1_set, w1_clr, r_set, r_clr;
  logic [N-1:0]   w0_cfg, w1_cfg, r_cfg;
  logic [TOT-1:0] nz_next, nz_now;
  logic [DW-1:0]  mb_q  [TOT];
  logic [CW-1:0]  cfg_q [N];
  logic [DW-1:0]  rd_word;

  mbx_decode #(.N(N), .M(M), .AW(AW), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE),
               .CFG_BASE(CFG_BASE)) dec_w0_i (
    .en(wr0_en), .addr(wr0_addr), .set_vec(w0_set), .clr_vec(w0_clr), .cfg_vec(w0_cfg));
  mbx_decode #(.N(N), .M(M), .AW(AW), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE),
               .CFG_BASE(CFG_BASE)) dec_w1_i (
    .en(wr1_en), .addr(wr1_addr), .set_vec(w1_set), .clr_vec(w1_clr), .cfg_vec(w1_cfg));
  mbx_decode #(.N(N), .M(M), .AW(AW), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE),
               .CFG_BASE(CFG_BASE)) dec_rd_i (
    .en(rd_en), .addr(rd_addr), .set_vec(r_set), .clr_vec(r_clr), .cfg_vec(r_cfg));

  for (genvar i = 0; i < TOT; i++) begin : g_cell
    logic [DW-1:0] set_m, clr_m;
    assign set_m = ({DW{w0_set[i]}} & wr0_data) | ({DW{w1_set[i]}} & wr1_data);
    assign clr_m = ({DW{w0_clr[i]}} & wr0_data) | ({DW{w1_clr[i]}} & wr1_data);
    assign nz_now[i] = (mb_q[i] != '0);
    mbx_cell #(.DW(DW)) cell_i (
      .clk(clk), .rst(rst), .set_mask(set_m), .clr_mask(clr_m),
      .q_o(mb_q[i]), .nz_next_o(nz_next[i]), .pend_o(mbox_pend[i]));
  end

  for (genvar n = 0; n < N; n++) begin : g_core
    mbx_core_irq #(.M(M), .RST_CFG(CW'(1))) core_i (
      .clk(clk), .rst(rst),
      .we0(w0_cfg[n]), .wd0(wr0_data[CW-1:0]),
      .we1(w1_cfg[n]), .wd1(wr1_data[CW-1:0]),
      .nz_next(nz_next[n*M +: M]),
      .cfg_q(cfg_q[n]), .irq_o(irq[n]), .fiq_o(fiq[n]));
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < TOT; i++)
      if (r_clr[i]) rd_word = rd_word | mb_q[i];
    for (int n = 0; n < N; n++)
      if (r_cfg[n]) rd_word = rd_word | DW'(cfg_q[n]);
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_word;
  end

  AST_PEND_TRACKS: assert property (@(posedge clk) disable iff (rst)
    mbox_pend == nz_now); // R7
  AST_SET_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (|r_set) |=> (rd_data == '0)); // R4
  AST_CLR_READ_WORD: assert property (@(posedge clk) disable iff (rst)
    ($onehot0(r_clr) && (|r_clr)) |=> (rd_data != '0) == $past(|(r_clr & nz_now))); // R3
endmodule

// File: tb/mbx_doorbell_tb_top.sv
`timescale 1ns/1ps
module mbx_doorbell_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr0_en = 1'b0, wr1_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wr0_addr = '0, wr1_addr = '0, rd_addr = '0;
  logic [31:0] wr0_data = '0, wr1_data = '0;
  logic [31:0] rd_data;
  logic [15:0] mbox_pend;
  logic [3:0]  irq, fiq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] mb  [16];
  logic [7:0]  cfg [4];

  always #2.5 clk = ~clk;

  mbx_doorbell dut_i (
    .clk(clk), .rst(rst),
    .wr0_en(wr0_en), .wr0_addr(wr0_addr), .wr0_data(wr0_data),
    .wr1_en(wr1_en), .wr1_addr(wr1_addr), .wr1_data(wr1_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .mbox_pend(mbox_pend), .irq(irq), .fiq(fiq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_pend();
    logic [15:0] p;
    for (int i = 0; i < 16; i++) p[i] = (mb[i] != 0);
    return p;
  endfunction

  function automatic logic [3:0] exp_line(input bit fast);
    logic [3:0] r;
    for (int n = 0; n < 4; n++) begin
      r[n] = 1'b0;
      for (int m = 0; m < 4; m++)
        if (mb[n*4+m] != 0 && cfg[n][fast ? m+4 : m]) r[n] = 1'b1;
    end
    return r;
  endfunction

  task automatic chk_outs(input string req);
    chk({req, " pend"}, 32'(mbox_pend), 32'(exp_pend()));
    chk({req, " irq"},  32'(irq), 32'(exp_line(1'b0)));
    chk({req, " fiq"},  32'(fiq), 32'(exp_line(1'b1)));
  endtask

  // Model one write channel's effect: gathers set/clear masks, applies config
  task automatic model_port(input bit en, input logic [7:0] a, input logic [31:0] d,
                            inout logic [31:0] sm [16], inout logic [31:0] cm [16]);
    if (!en || a[1:0] != 2'b00) return;
    if (a >= 8'h80 && a < 8'hC0) sm[(a - 8'h80) >> 2] |= d;
    else if (a >= 8'hC0)         cm[(a - 8'hC0) >> 2] |= d;
    else if (a >= 8'h20 && a < 8'h30) cfg[(a - 8'h20) >> 2] = d[7:0];
  endtask

  task automatic wr2(input bit e0, input logic [7:0] a0, input logic [31:0] d0,
                     input bit e1, input logic [7:0] a1, input logic [31:0] d1);
    logic [31:0] sm [16];
    logic [31:0] cm [16];
    @(negedge clk);
    wr0_en = e0; wr0_addr = a0; wr0_data = d0;
    wr1_en = e1; wr1_addr = a1; wr1_data = d1;
    @(posedge clk);
    for (int i = 0; i < 16; i++) begin sm[i] = '0; cm[i] = '0; end
    model_port(e0, a0, d0, sm, cm);
    model_port(e1, a1, d1, sm, cm);
    for (int i = 0; i < 16; i++) mb[i] = (mb[i] & ~cm[i]) | sm[i];
    @(negedge clk);
    wr0_en = 1'b0; wr1_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr2(1'b1, a, d, 1'b0, 8'h00, 32'h0);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, rd_data, exp);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mb[i] = '0;
    for (int n = 0; n < 4; n++) cfg[n] = 8'h01;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R5: reset state
    chk("R5 rd_data", rd_data, 32'h0);
    chk_outs("R5");
    for (int n = 0; n < 4; n++) rd_chk("R5 cfg", 8'(8'h20 + 4*n), 32'h1);
    rd_chk("R5 mailbox", 8'hC0, 32'h0);

    // R1/R3/R4/R7/R8: set sweep over all mailboxes
    for (int i = 0; i < 16; i++) begin
      logic [31:0] p;
      p = (32'h1 << i) | (32'h5A000000 ^ (32'(i) << 16));
      wr(8'(8'h80 + 4*i), p);
      chk_outs("R7 R8 set");
      rd_chk("R3 clear-alias read", 8'(8'hC0 + 4*i), mb[i]);
      rd_chk("R4 set-alias read", 8'(8'h80 + 4*i), 32'h0);
      wr(8'(8'h80 + 4*i), 32'h00000F00);
      rd_chk("R1 OR accumulate", 8'(8'hC0 + 4*i), mb[i]);
    end

    // R2: partial clear then full clear
    for (int i = 0; i < 16; i++) begin
      wr(8'(8'hC0 + 4*i), 32'h0000FFFF);
      rd_chk("R2 partial clear", 8'(8'hC0 + 4*i), mb[i]);
      chk_outs("R2 partial");
    end
    for (int i = 0; i < 16; i++) begin
      wr(8'(8'hC0 + 4*i), 32'hFFFFFFFF);
      chk_outs("R7 drop");
    end
    for (int i = 0; i < 16; i++) rd_chk("R2 cleared", 8'(8'hC0 + 4*i), 32'h0);

    // R6/R8: exhaustive configuration sweep with mailboxes 1 and 3 of each core busy
    for (int n = 0; n < 4; n++) begin
      wr(8'(8'h80 + 16*n + 4), 32'h1);
      wr(8'(8'h80 + 16*n + 12), 32'h8000_0000);
    end
    for (int n = 0; n < 4; n++)
      for (int v = 0; v < 256; v++) begin
        wr(8'(8'h20 + 4*n), 32'hFFFFFF00 | 32'(v));
        chk_outs("R6 R8 cfg sweep");
        if (v % 37 == 0) rd_chk("R6 cfg readback", 8'(8'h20 + 4*n), 32'(v));
      end

    // R8: output changes on the edge sampling the write, not before
    wr(8'h20, 32'h01);
    @(negedge clk);
    wr0_en = 1'b1; wr0_addr = 8'h80; wr0_data = 32'h4;
    #1 chk("R8 before edge", 32'(irq[0]), 32'h0);
    @(posedge clk); mb[0] |= 32'h4;
    @(negedge clk); wr0_en = 1'b0;
    chk("R8 after edge", 32'(irq[0]), 32'h1);

    // R9: set and clear of the same mailbox in one cycle
    wr(8'h94, 32'hFFFF0000);
    wr2(1'b1, 8'h94, 32'h000000FF, 1'b1, 8'hD4, 32'hFFFFFFFF);
    rd_chk("R9 set beats clear", 8'hD4, 32'h000000FF);
    wr2(1'b1, 8'hD4, 32'h0000000F, 1'b1, 8'h94, 32'h00F00003);
    rd_chk("R9 swapped channels", 8'hD4, mb[5]);
    chk_outs("R9 outs");
    wr2(1'b1, 8'hD4, 32'hFFFFFFFF, 1'b1, 8'hD4, 32'h0);
    chk_outs("R9 clear all");

    // R10: dual set ORs, dual config write keeps channel 1
    wr2(1'b1, 8'hA8, 32'h00000011, 1'b1, 8'hA8, 32'h11000000);
    rd_chk("R10 dual set", 8'hE8, 32'h11000011);
    wr2(1'b1, 8'h28, 32'h000000F0, 1'b1, 8'h28, 32'h0000000F);
    rd_chk("R10 cfg priority", 8'h28, 32'h0F);
    chk_outs("R10 outs");

    // R4: unmapped and misaligned accesses
    wr(8'h81, 32'hFFFFFFFF);
    wr(8'h04, 32'hFFFFFFFF);
    wr(8'h30, 32'hFFFFFFFF);
    chk_outs("R4 ignored write");
    for (int i = 0; i < 16; i++) rd_chk("R4 ignored write mb", 8'(8'hC0 + 4*i), mb[i]);
    for (int n = 0; n < 4; n++) rd_chk("R4 ignored write cfg", 8'(8'h20 + 4*n), 32'(cfg[n]));
    rd_chk("R4 misaligned read", 8'hE9, 32'h0);
    rd_chk("R4 unmapped read", 8'h40, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule